// File: doc/BRIEF.md
# Virtually-Indexed Physically-Tagged Cache Lookup

This unit is the read-lookup side of a set-associative first-level cache. It selects the set from untranslated low address bits. The tag, valid and data arrays are read in the same cycle that a request is accepted, and the address translator handles the same virtual address in that cycle too. When the translator returns a physical page number, the unit compares it with the stored physical tag of every way. It then answers with a hit, the way that hit and the line data, or with a miss.

When the set index and line offset together use more bits than the page offset, the top index bits come from the virtual page number. A single physical line could then sit in several sets. On every miss in that configuration, the unit visits each candidate set in turn, one per cycle. It invalidates any line whose physical tag equals the translated page number, and only then reports the miss. The next level later writes the missing line through the fill port. The victim way in each set is chosen by a round-robin pointer kept for that set.

Requests, fills and responses are valid/ready streams. A request is taken only when the unit is idle and no fill is offered, so a fill always wins over a request. The response is held, unchanged, until it is accepted. The translator response is a plain input that is sampled while a lookup waits for it.

Top module: `vipt_lookup`

## Requirements
- R1: After reset, `req_ready` and `fill_ready` are 1, `rsp_valid` is 0, and every line is invalid.
- R2: The set index is `req_va[OFF_W +: IDX_W]`, with OFF_W = log2(LINE_BYTES) and IDX_W = log2(SETS). The arrays are read at acceptance. A hit response appears in the cycle after the one in which `tlb_valid` and `tlb_hit` are both sampled high. Virtual address bits outside the index field have no effect on the result.
- R3: A hit requires a valid line in the indexed set whose stored tag equals `tlb_ppn`. All ways are compared. On a hit, `rsp_hit`=1, `rsp_way` gives the matching way and `rsp_data` gives its line.
- R4: While `tlb_valid` is low, or `tlb_valid` is high with `tlb_hit` low, the lookup stays pending and `rsp_valid` remains 0.
- R5: Let ALIAS_W = IDX_W + OFF_W − PAGE_OFF_W. When ALIAS_W > 0, a miss probes 2^ALIAS_W candidate sets, one per cycle. The candidate sets keep the lower IDX_W−ALIAS_W index bits and run the upper bits from 0 upward. The miss response therefore comes 2^ALIAS_W cycles later than a hit would.
- R6: During the probe, every valid line in a candidate set whose tag equals the translated page number is invalidated. Lines with other tags survive.
- R7: A miss response has `rsp_hit`=0, `rsp_way`=0 and `rsp_data`=0.
- R8: A fill writes the set selected by `fill_va[OFF_W +: IDX_W]`. It goes into the way named by that set's round-robin pointer, which starts at 0 and advances by one, modulo WAYS, on each fill to that set. The filled line becomes valid with tag `fill_ppn`.
- R9: `fill_ready` is high only when idle. `req_ready` is high only when idle and `fill_valid` is low.
- R10: While `rsp_valid` is high and `rsp_ready` is low, the response and all of its fields stay unchanged.
- R11: From acceptance until the response handshake, `req_ready` and `fill_ready` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request offered |
| req_ready | output | 1 | Lookup request accepted this cycle if valid |
| req_va | input | VA_W | Virtual address of the lookup |
| tlb_valid | input | 1 | Translator response present |
| tlb_hit | input | 1 | Translator found a mapping |
| tlb_ppn | input | PPN_W | Translated physical page number |
| rsp_valid | output | 1 | Lookup result available |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_hit | output | 1 | 1 on hit, 0 on miss |
| rsp_way | output | WAY_W | Way that hit |
| rsp_data | output | LINE_BYTES*8 | Line read on hit |
| fill_valid | input | 1 | Line fill offered |
| fill_ready | output | 1 | Line fill accepted this cycle if valid |
| fill_va | input | VA_W | Virtual address selecting the fill set |
| fill_ppn | input | PPN_W | Physical tag of the filled line |
| fill_data | input | LINE_BYTES*8 | Filled line contents |

## Verification
A line fill and a lookup request can be offered in the same idle cycle. The bench raises both valids on one edge and checks that only the fill is taken: `req_ready` is low and `fill_ready` is high in that cycle. The request then follows one cycle later and must hit the line just written, in the way the round-robin pointer predicted. A second overlap occurs when a miss probe runs: invalidation of an alias and the reported miss are separated in time, and the evicted line must be absent from the very next lookup of its other virtual address.

// File: rtl/vipt_pkg.sv
package vipt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOOK  = 2'd1,
    ST_PROBE = 2'd2,
    ST_RESP  = 2'd3
  } lk_state_e;
endpackage

// File: rtl/vipt_way_store.sv
// One way: valid bits, physical tags and line data, with a lookup read
// port, a probe read port, a fill write port and an invalidate port.
module vipt_way_store #(
  parameter int SETS   = 16,
  parameter int IDX_W  = 4,
  parameter int TAG_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  lk_idx,
  output logic              lk_valid,
  output logic [TAG_W-1:0]  lk_tag,
  output logic [DATA_W-1:0] lk_data,
  input  logic [IDX_W-1:0]  pr_idx,
  output logic              pr_valid,
  output logic [TAG_W-1:0]  pr_tag,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              inv_en,
  input  logic [IDX_W-1:0]  inv_idx
);
  logic [SETS-1:0]   valid_q;
  logic [TAG_W-1:0]  tag_q  [SETS];
  logic [DATA_W-1:0] data_q [SETS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else if (wr_en) begin
      valid_q[wr_idx] <= 1'b1;
    end else if (inv_en) begin
      valid_q[inv_idx] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx]  <= wr_tag;
      data_q[wr_idx] <= wr_data;
    end
  end

  assign lk_valid = valid_q[lk_idx];
  assign lk_tag   = tag_q[lk_idx];
  assign lk_data  = data_q[lk_idx];
  assign pr_valid = valid_q[pr_idx];
  assign pr_tag   = tag_q[pr_idx];
endmodule

// File: rtl/vipt_rr_repl.sv
// Per-set round-robin victim pointer.
module vipt_rr_repl #(
  parameter int SETS  = 16,
  parameter int IDX_W = 4,
  parameter int WAYS  = 2,
  parameter int WAY_W = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] sel_idx,
  input  logic             adv_en,
  output logic [WAY_W-1:0] victim
);
  logic [WAY_W-1:0] ptr_q [SETS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) ptr_q[s] <= '0;
    end else if (adv_en) begin
      ptr_q[sel_idx] <= (ptr_q[sel_idx] == WAY_W'(WAYS - 1)) ? '0 : ptr_q[sel_idx] + 1'b1;
    end
  end

  assign victim = ptr_q[sel_idx];
endmodule

// File: rtl/vipt_alias_probe.sv
// Sequencer stepping through the candidate alias sets, one per cycle.
module vipt_alias_probe #(
  parameter int ALIAS_N = 4,
  parameter int CNT_W   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             busy,
  output logic [CNT_W-1:0] cnt,
  output logic             last
);
  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;

  assign last = busy_q && (cnt_q == CNT_W'(ALIAS_N - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (last) busy_q <= 1'b0;
      else      cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign busy = busy_q;
  assign cnt  = cnt_q;
endmodule

// File: rtl/vipt_lookup.sv
module vipt_lookup
  import vipt_pkg::*;
#(
  parameter int VA_W       = 16,
  parameter int PPN_W      = 8,
  parameter int PAGE_OFF_W = 4,
  parameter int LINE_BYTES = 4,
  parameter int SETS       = 16,
  parameter int WAYS       = 2,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int IDX_W     = $clog2(SETS),
  localparam int DATA_W    = LINE_BYTES * 8,
  localparam int WAY_W     = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_va,
  input  logic              tlb_valid,
  input  logic              tlb_hit,
  input  logic [PPN_W-1:0]  tlb_ppn,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_hit,
  output logic [WAY_W-1:0]  rsp_way,
  output logic [DATA_W-1:0] rsp_data,
  input  logic              fill_valid,
  output logic              fill_ready,
  input  logic [VA_W-1:0]   fill_va,
  input  logic [PPN_W-1:0]  fill_ppn,
  input  logic [DATA_W-1:0] fill_data
);
  localparam int ALIAS_RAW = IDX_W + OFF_W - PAGE_OFF_W;
  localparam int ALIAS_W   = (ALIAS_RAW > 0) ? ALIAS_RAW : 0;
  localparam int ALIAS_N   = 1 << ALIAS_W;
  localparam int CNT_W     = (ALIAS_W > 0) ? ALIAS_W : 1;
  localparam int LOW_W     = IDX_W - ALIAS_W;

  lk_state_e state_q, state_d;

  logic             idle, req_go, fill_go, xlate_ok;
  logic [IDX_W-1:0] req_idx, fill_idx, home_idx_q, cand_idx;
  logic [PPN_W-1:0] ppn_q;

  // Array read ports, per way
  logic [WAYS-1:0]   lk_valid, pr_valid, hit_vec, pr_match, wr_sel;
  logic [PPN_W-1:0]  lk_tag  [WAYS];
  logic [PPN_W-1:0]  pr_tag  [WAYS];
  logic [DATA_W-1:0] lk_data [WAYS];

  // Read results captured at acceptance
  logic [WAYS-1:0]   rd_valid_q;
  logic [PPN_W-1:0]  rd_tag_q  [WAYS];
  logic [DATA_W-1:0] rd_data_q [WAYS];

  logic              any_hit;
  logic [WAY_W-1:0]  hit_way, victim;
  logic [DATA_W-1:0] hit_data;

  logic              probe_busy, probe_last, probe_start;
  logic [CNT_W-1:0]  probe_cnt;

  logic              rsp_hit_q;
  logic [WAY_W-1:0]  rsp_way_q;
  logic [DATA_W-1:0] rsp_data_q;

  assign idle       = (state_q == ST_IDLE);
  assign fill_ready = idle;
  assign req_ready  = idle && !fill_valid;
  assign fill_go    = fill_valid && idle;
  assign req_go     = req_valid && req_ready;
  assign req_idx    = req_va[OFF_W +: IDX_W];
  assign fill_idx   = fill_va[OFF_W +: IDX_W];
  assign xlate_ok   = (state_q == ST_LOOK) && tlb_valid && tlb_hit;

  // Candidate set for the alias probe
  generate
    if (ALIAS_W == 0) begin : g_cand_none
      assign cand_idx = home_idx_q;
    end else if (LOW_W == 0) begin : g_cand_all
      assign cand_idx = probe_cnt[ALIAS_W-1:0];
    end else begin : g_cand_mix
      assign cand_idx = {probe_cnt[ALIAS_W-1:0], home_idx_q[LOW_W-1:0]};
    end
  endgenerate

  generate
    for (genvar w = 0; w < WAYS; w++) begin : g_way
      assign wr_sel[w]   = fill_go && (victim == WAY_W'(w));
      assign pr_match[w] = probe_busy && pr_valid[w] && (pr_tag[w] == ppn_q);
      assign hit_vec[w]  = rd_valid_q[w] && (rd_tag_q[w] == tlb_ppn);

      vipt_way_store #(
        .SETS(SETS), .IDX_W(IDX_W), .TAG_W(PPN_W), .DATA_W(DATA_W)
      ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .lk_idx   (req_idx),
        .lk_valid (lk_valid[w]),
        .lk_tag   (lk_tag[w]),
        .lk_data  (lk_data[w]),
        .pr_idx   (cand_idx),
        .pr_valid (pr_valid[w]),
        .pr_tag   (pr_tag[w]),
        .wr_en    (wr_sel[w]),
        .wr_idx   (fill_idx),
        .wr_tag   (fill_ppn),
        .wr_data  (fill_data),
        .inv_en   (pr_match[w]),
        .inv_idx  (cand_idx)
      );

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          rd_valid_q[w] <= 1'b0;
        end else if (req_go) begin
          rd_valid_q[w] <= lk_valid[w];
          rd_tag_q[w]   <= lk_tag[w];
          rd_data_q[w]  <= lk_data[w];
        end
      end
    end
  endgenerate

  always_comb begin
    any_hit  = |hit_vec;
    hit_way  = '0;
    hit_data = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (hit_vec[w]) begin
        hit_way  = WAY_W'(w);
        hit_data = rd_data_q[w];
      end
    end
  end

  vipt_rr_repl #(
    .SETS(SETS), .IDX_W(IDX_W), .WAYS(WAYS), .WAY_W(WAY_W)
  ) u_rr (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel_idx (fill_idx),
    .adv_en  (fill_go),
    .victim  (victim)
  );

  assign probe_start = xlate_ok && !any_hit && (ALIAS_W > 0);

  generate
    if (ALIAS_W > 0) begin : g_probe
      vipt_alias_probe #(.ALIAS_N(ALIAS_N), .CNT_W(CNT_W)) u_probe (
        .clk   (clk),
        .rst_n (rst_n),
        .start (probe_start),
        .busy  (probe_busy),
        .cnt   (probe_cnt),
        .last  (probe_last)
      );
    end else begin : g_no_probe
      assign probe_busy = 1'b0;
      assign probe_cnt  = '0;
      assign probe_last = 1'b0;
    end
  endgenerate

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (req_go) state_d = ST_LOOK;
      ST_LOOK:  if (xlate_ok) state_d = (!any_hit && ALIAS_W > 0) ? ST_PROBE : ST_RESP;
      ST_PROBE: if (probe_last) state_d = ST_RESP;
      ST_RESP:  if (rsp_ready) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      home_idx_q <= '0;
      ppn_q      <= '0;
      rsp_hit_q  <= 1'b0;
      rsp_way_q  <= '0;
      rsp_data_q <= '0;
    end else begin
      state_q <= state_d;
      if (req_go) home_idx_q <= req_idx;
      if (xlate_ok) begin
        ppn_q      <= tlb_ppn;
        rsp_hit_q  <= any_hit;
        rsp_way_q  <= any_hit ? hit_way  : '0;
        rsp_data_q <= any_hit ? hit_data : '0;
      end
    end
  end

  assign rsp_valid = (state_q == ST_RESP);
  assign rsp_hit   = rsp_hit_q;
  assign rsp_way   = rsp_way_q;
  assign rsp_data  = rsp_data_q;
endmodule

// File: rtl/vipt_lookup_chk.sv
module vipt_lookup_chk #(
  parameter int WAY_W  = 1,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              fill_valid,
  input logic              fill_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic              rsp_hit,
  input logic [WAY_W-1:0]  rsp_way,
  input logic [DATA_W-1:0] rsp_data,
  input logic              probe_busy
);
  AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_hit) && $stable(rsp_way) && $stable(rsp_data)); // R10

  AST_FILL_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |-> !req_ready); // R9

  AST_BUSY_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready && !fill_ready); // R11

  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_hit |-> rsp_way == '0 && rsp_data == '0); // R7

  AST_PROBE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    probe_busy |-> !rsp_valid && !req_ready && !fill_ready); // R5
endmodule

bind vipt_lookup vipt_lookup_chk #(.WAY_W(WAY_W), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_ready  (req_ready),
  .fill_valid (fill_valid),
  .fill_ready (fill_ready),
  .rsp_valid  (rsp_valid),
  .rsp_ready  (rsp_ready),
  .rsp_hit    (rsp_hit),
  .rsp_way    (rsp_way),
  .rsp_data   (rsp_data),
  .probe_busy (probe_busy)
);

// File: tb/vipt_lookup_tb.sv
module vipt_lookup_tb;
  localparam int NSETS = 16;
  localparam int NWAYS = 2;
  localparam int NCAND = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [15:0] req_va = '0;
  logic        tlb_valid = 1'b0;
  logic        tlb_hit = 1'b0;
  logic [7:0]  tlb_ppn = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic        rsp_hit;
  logic [0:0]  rsp_way;
  logic [31:0] rsp_data;
  logic        fill_valid = 1'b0;
  logic        fill_ready;
  logic [15:0] fill_va = '0;
  logic [7:0]  fill_ppn = '0;
  logic [31:0] fill_data = '0;

  always #5 clk = ~clk;

  vipt_lookup u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va),
    .tlb_valid(tlb_valid), .tlb_hit(tlb_hit), .tlb_ppn(tlb_ppn),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_hit(rsp_hit),
    .rsp_way(rsp_way), .rsp_data(rsp_data),
    .fill_valid(fill_valid), .fill_ready(fill_ready), .fill_va(fill_va),
    .fill_ppn(fill_ppn), .fill_data(fill_data)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit mon_on  = 1'b0;
  bit exp_idle = 1'b1;

  // Reference model state
  bit          mv [NSETS][NWAYS];
  logic [7:0]  mt [NSETS][NWAYS];
  logic [31:0] md [NSETS][NWAYS];
  int          rr [NSETS];

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int idx_of(input logic [15:0] va);
    return int'((va >> 2) & 16'hF);
  endfunction

  task automatic model_fill(input logic [15:0] va, input logic [7:0] ppn, input logic [31:0] d);
    int s = idx_of(va);
    int w = rr[s];
    mv[s][w] = 1'b1;
    mt[s][w] = ppn;
    md[s][w] = d;
    rr[s] = (rr[s] + 1) % NWAYS;
  endtask

  // Per-cycle comparison of the handshake readiness against the model
  always @(negedge clk) begin
    #1;
    if (mon_on) begin
      check(fill_ready == exp_idle, "R9 fill_ready", fill_ready, exp_idle);
      check(req_ready == (exp_idle && !fill_valid), "R11 req_ready", req_ready, exp_idle && !fill_valid);
    end
  end

  task automatic fill(input logic [15:0] va, input logic [7:0] ppn, input logic [31:0] d);
    @(negedge clk);
    fill_va = va; fill_ppn = ppn; fill_data = d; fill_valid = 1'b1;
    @(posedge clk);
    model_fill(va, ppn, d);
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  task automatic lookup(input logic [15:0] va, input logic [7:0] ppn, input int tlb_wait,
                        input int tlb_miss, input int hold, input bit cf,
                        input logic [7:0] cf_ppn, input logic [31:0] cf_data, input string tag);
    bit          e_hit = 1'b0;
    int          e_way = 0;
    logic [31:0] e_data = '0;
    int          e_lat, lat, s;
    logic [31:0] first_data;
    @(negedge clk);
    req_va = va; req_valid = 1'b1;
    if (cf) begin
      fill_va = va; fill_ppn = cf_ppn; fill_data = cf_data; fill_valid = 1'b1;
      #1;
      check(req_ready == 1'b0 && fill_ready == 1'b1, {"R9 fill before request ", tag},
            {req_ready, fill_ready}, 2'b01);
      @(posedge clk);
      model_fill(va, cf_ppn, cf_data);
      @(negedge clk);
      fill_valid = 1'b0;
    end
    @(posedge clk);
    exp_idle = 1'b0;
    s = idx_of(va);
    for (int w = 0; w < NWAYS; w++)
      if (mv[s][w] && mt[s][w] == ppn) begin e_hit = 1'b1; e_way = w; e_data = md[s][w]; end
    if (!e_hit)
      for (int k = 0; k < NCAND; k++)
        for (int w = 0; w < NWAYS; w++)
          if (mv[k*4 + (s % 4)][w] && mt[k*4 + (s % 4)][w] == ppn) mv[k*4 + (s % 4)][w] = 1'b0;
    e_lat = e_hit ? 0 : NCAND;
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < tlb_wait; i++) @(negedge clk);
    for (int i = 0; i < tlb_miss; i++) begin
      tlb_valid = 1'b1; tlb_hit = 1'b0; tlb_ppn = ppn ^ 8'hFF;
      @(negedge clk);
    end
    if (tlb_wait + tlb_miss > 0)
      check(rsp_valid == 1'b0, {"R4 pending without translation ", tag}, rsp_valid, 0);
    tlb_valid = 1'b1; tlb_hit = 1'b1; tlb_ppn = ppn;
    @(negedge clk);
    tlb_valid = 1'b0; tlb_hit = 1'b0;
    lat = 0;
    while (!rsp_valid && lat < 20) begin @(negedge clk); lat++; end
    check(lat == e_lat, e_hit ? {"R2 hit latency ", tag} : {"R5 miss latency ", tag}, lat, e_lat);
    check(rsp_hit == e_hit, {"R3 hit flag ", tag}, rsp_hit, e_hit);
    check(int'(rsp_way) == e_way, e_hit ? {"R3 way ", tag} : {"R7 miss way ", tag}, rsp_way, e_way);
    check(rsp_data == e_data, e_hit ? {"R3 data ", tag} : {"R7 miss data ", tag}, rsp_data, e_data);
    if (hold > 0) begin
      first_data = rsp_data;
      repeat (hold) @(negedge clk);
      check(rsp_valid && rsp_data == first_data && rsp_hit == e_hit, {"R10 held response ", tag},
            rsp_data, first_data);
    end
    rsp_ready = 1'b1;
    @(posedge clk);
    exp_idle = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  initial begin
    for (int s = 0; s < NSETS; s++) begin
      rr[s] = 0;
      for (int w = 0; w < NWAYS; w++) begin mv[s][w] = 1'b0; mt[s][w] = '0; md[s][w] = '0; end
    end
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1, "R1 req_ready after reset", req_ready, 1);
    check(fill_ready == 1'b1, "R1 fill_ready after reset", fill_ready, 1);
    check(rsp_valid == 1'b0, "R1 rsp_valid after reset", rsp_valid, 0);
    mon_on = 1'b1;

    lookup(16'h0010, 8'h12, 0, 0, 0, 1'b0, 8'h0, 32'h0, "R1 empty cache misses");
    fill(16'h0010, 8'h12, 32'hAAAA_0001);
    lookup(16'h0010, 8'h12, 0, 0, 0, 1'b0, 8'h0, 32'h0, "basic hit");
    lookup(16'h0010, 8'h34, 0, 0, 0, 1'b0, 8'h0, 32'h0, "tag mismatch");
    fill(16'h0010, 8'h34, 32'hBBBB_0002);
    lookup(16'h0010, 8'h34, 0, 0, 0, 1'b0, 8'h0, 32'h0, "R8 second way");
    fill(16'h0010, 8'h56, 32'hCCCC_0003);
    lookup(16'h0010, 8'h12, 0, 0, 0, 1'b0, 8'h0, 32'h0, "R8 way0 replaced");
    lookup(16'h0010, 8'h56, 0, 0, 0, 1'b0, 8'h0, 32'h0, "R8 wrap to way0");
    lookup(16'h0011, 8'h56, 0, 0, 0, 1'b0, 8'h0, 32'h0, "R2 byte offset ignored");
    lookup(16'h1010, 8'h56, 0, 0, 0, 1'b0, 8'h0, 32'h0, "R2 upper va bits ignored");
    lookup(16'h0030, 8'h34, 0, 0, 0, 1'b0, 8'h0, 32'h0, "R6 alias probe");
    lookup(16'h0010, 8'h34, 0, 0, 0, 1'b0, 8'h0, 32'h0, "R6 alias evicted");
    lookup(16'h0010, 8'h56, 0, 0, 0, 1'b0, 8'h0, 32'h0, "R6 other tag kept");
    lookup(16'h0010, 8'h56, 2, 3, 0, 1'b0, 8'h0, 32'h0, "R4 late translation");
    lookup(16'h0010, 8'h56, 0, 0, 3, 1'b0, 8'h0, 32'h0, "R10 back-pressure");
    lookup(16'h0030, 8'h99, 0, 0, 3, 1'b0, 8'h0, 32'h0, "R10 held miss");
    lookup(16'h0024, 8'h77, 0, 0, 0, 1'b1, 8'h77, 32'hDDDD_0004, "R9 same-cycle fill");

    mon_on = 1'b0;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule